// File: doc/BRIEF.md
# Transfer-Engine Control and Status Register Bank

This block is the software-facing register bank of a read-only engine that moves sectors from a memory card into system memory. An AXI4-Lite slave with a 4 KB window and 32-bit words sits on one side. The other side faces the engine. It drives the engine's configuration: destination address, first sector, sector count and interrupt enable. It also produces two single-cycle command pulses, one to launch a transfer and one to soft-reset the engine.

The engine reports back through several inputs: busy, a DMA error flag, a 4-bit card state, a 2-bit card kind, a running count of bytes delivered, and a one-cycle completion event. The bank folds these into a status word and a progress word. The completion event sets a sticky pending flag. Software clears that flag by writing 1 to its bit, the only writable bit in the status word. The level interrupt output is the pending flag gated by the enable bit.

Write address and write data may arrive in either order or together. Each pair causes exactly one register update and one OKAY response. Only address bits 11:0 are decoded, so the window repeats across the rest of the address space. A read of any offset without a register returns zero.

Top module: `dma_csr_bank`

## Requirements
- R1: After synchronous reset, every configuration output, the command pulses, the interrupt and both response valids are 0, and every register reads as 0.
- R2: Offset 0x08 (destination address) and offset 0x0C (first sector) are full 32-bit read/write registers. Each write lane n updates byte n only when write-strobe bit n is set.
- R3: Offset 0x10 (sector count) keeps only bits 22:1 of what is written. Bit 0 and bits 31:23 always read as 0, so the count is always even.
- R4: At offset 0x00, bit 1 is the interrupt enable and reads back as written. Bit 0 (start) and bits 31:2 always read as 0.
- R5: Writing 1 to bit 0 of offset 0x00 gives a one-cycle start pulse. The pulse appears only when the engine is not busy and the stored sector count is nonzero; otherwise the request is dropped.
- R6: Offset 0x04 reads {23'b0, card state[3:0] in bits 8:5, card kind[1:0] in bits 4:3, pending in bit 2, DMA error in bit 1, busy in bit 0}, sampled at the read.
- R7: The completion event sets pending whether or not interrupts are enabled. Writing 1 to bit 2 of offset 0x04 clears pending, but a completion in the same cycle keeps it set. All other status bits ignore writes.
- R8: The interrupt output is high exactly when pending and the interrupt enable are both 1.
- R9: Offset 0x14 reads the engine's byte-progress input, and writes to it have no effect.
- R10: Writing 1 to bit 0 of offset 0x18 gives a one-cycle soft-reset pulse. Writing 0 gives none, and the offset always reads 0.
- R11: Write address and write data are accepted in any order. Each pair causes one register update and one write response with code 00 (OKAY).
- R12: Only address bits 11:0 are decoded. Offsets that have no register read as 0 with response code 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_awaddr | input | 32 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 32 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| cfg_start_pulse | output | 1 | One-cycle transfer launch |
| cfg_dst_addr | output | 32 | Destination address |
| cfg_first_sector | output | 32 | First sector to read |
| cfg_sector_cnt | output | 32 | Sector count, always even |
| cfg_irq_en | output | 1 | Interrupt enable |
| cfg_soft_rst | output | 1 | One-cycle engine soft reset |
| eng_busy | input | 1 | Engine is transferring |
| eng_dma_err | input | 1 | Engine memory-write error |
| eng_card_state | input | 4 | Engine card state code |
| eng_card_kind | input | 2 | Detected card kind |
| eng_bytes_done | input | 32 | Bytes delivered so far |
| eng_done | input | 1 | One-cycle transfer completion |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is a clear of the pending flag that lands in the same cycle as a new completion. If the clear won, that event would be lost. The bench holds the completion input high across a whole clearing write, so every cycle of the write overlaps an event, and then checks that pending still reads 1. The rejected start requests are also hard to observe, because nothing happens when they are dropped. The bench counts start pulses at the port. It first attempts starts with a zero count, then with the engine busy, and checks that the count has not moved before it makes a valid request.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned OFS_W  = 12;
    localparam int unsigned STRB_W = DATA_W / 8;

    localparam logic [OFS_W-1:0] OFS_CTRL  = 12'h000;
    localparam logic [OFS_W-1:0] OFS_STAT  = 12'h004;
    localparam logic [OFS_W-1:0] OFS_DST   = 12'h008;
    localparam logic [OFS_W-1:0] OFS_SECT  = 12'h00C;
    localparam logic [OFS_W-1:0] OFS_COUNT = 12'h010;
    localparam logic [OFS_W-1:0] OFS_PROG  = 12'h014;
    localparam logic [OFS_W-1:0] OFS_SRST  = 12'h018;

    localparam logic [DATA_W-1:0] COUNT_KEEP = 32'h007F_FFFE;
    localparam logic [1:0]        RESP_OKAY  = 2'b00;

    typedef struct packed {
        logic [OFS_W-1:0]  ofs;
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
    } wr_req_t;

    typedef struct packed {
        logic [3:0] state;
        logic [1:0] kind;
        logic       pend;
        logic       err;
        logic       busy;
    } stat_word_t;

    function automatic logic [DATA_W-1:0] merge_lanes(
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] upd,
        input logic [STRB_W-1:0] strb
    );
        logic [DATA_W-1:0] res;
        for (int b = 0; b < STRB_W; b++) begin
            res[b*8 +: 8] = strb[b] ? upd[b*8 +: 8] : cur[b*8 +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/csr_wr_join.sv
module csr_wr_join
    import dma_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    output logic              wr_fire,
    output wr_req_t           wr_req
);
    logic             aw_full;
    logic             w_full;
    logic [OFS_W-1:0] ofs_q;
    logic [DATA_W-1:0] data_q;
    logic [STRB_W-1:0] strb_q;

    assign awready = !aw_full && !bvalid;
    assign wready  = !w_full && !bvalid;
    assign wr_fire = aw_full && w_full;
    assign bresp   = RESP_OKAY;
    assign wr_req  = '{ofs: ofs_q, data: data_q, strb: strb_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            aw_full <= 1'b0;
            w_full  <= 1'b0;
            bvalid  <= 1'b0;
            ofs_q   <= '0;
            data_q  <= '0;
            strb_q  <= '0;
        end else begin
            if (awvalid && awready) begin
                aw_full <= 1'b1;
                ofs_q   <= awaddr[OFS_W-1:0];
            end
            if (wvalid && wready) begin
                w_full <= 1'b1;
                data_q <= wdata;
                strb_q <= wstrb;
            end
            if (wr_fire) begin
                aw_full <= 1'b0;
                w_full  <= 1'b0;
                bvalid  <= 1'b1;
            end else if (bvalid && bready) begin
                bvalid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/csr_rd_port.sv
module csr_rd_port
    import dma_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    output logic [OFS_W-1:0]  rd_ofs,
    input  logic [DATA_W-1:0] rd_word
);
    assign arready = !rvalid;
    assign rresp   = RESP_OKAY;
    assign rd_ofs  = araddr[OFS_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (arvalid && arready) begin
            rvalid <= 1'b1;
            rdata  <= rd_word;
        end else if (rvalid && rready) begin
            rvalid <= 1'b0;
        end
    end
endmodule

// File: rtl/csr_irq_pend.sv
module csr_irq_pend (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_req,
    input  logic enable,
    output logic pend,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (set_evt) begin
            pend <= 1'b1;
        end else if (clr_req) begin
            pend <= 1'b0;
        end
    end

    assign irq = pend && enable;
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
    import dma_csr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] s_awaddr,
    input  logic        s_awvalid,
    output logic        s_awready,
    input  logic [31:0] s_wdata,
    input  logic [3:0]  s_wstrb,
    input  logic        s_wvalid,
    output logic        s_wready,
    output logic [1:0]  s_bresp,
    output logic        s_bvalid,
    input  logic        s_bready,
    input  logic [31:0] s_araddr,
    input  logic        s_arvalid,
    output logic        s_arready,
    output logic [31:0] s_rdata,
    output logic [1:0]  s_rresp,
    output logic        s_rvalid,
    input  logic        s_rready,
    output logic        cfg_start_pulse,
    output logic [31:0] cfg_dst_addr,
    output logic [31:0] cfg_first_sector,
    output logic [31:0] cfg_sector_cnt,
    output logic        cfg_irq_en,
    output logic        cfg_soft_rst,
    input  logic        eng_busy,
    input  logic        eng_dma_err,
    input  logic [3:0]  eng_card_state,
    input  logic [1:0]  eng_card_kind,
    input  logic [31:0] eng_bytes_done,
    input  logic        eng_done,
    output logic        irq
);
    logic             wr_fire;
    wr_req_t          wr_req;
    logic [OFS_W-1:0] rd_ofs;
    logic [DATA_W-1:0] rd_word;
    logic             pend;
    logic             clr_req;
    logic             lane0;
    stat_word_t       stat_now;

    csr_wr_join u_wr (
        .clk(clk), .rst(rst),
        .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
        .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
        .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
        .wr_fire(wr_fire), .wr_req(wr_req)
    );

    csr_rd_port u_rd (
        .clk(clk), .rst(rst),
        .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
        .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
        .rd_ofs(rd_ofs), .rd_word(rd_word)
    );

    assign lane0   = wr_fire && wr_req.strb[0];
    assign clr_req = lane0 && (wr_req.ofs == OFS_STAT) && wr_req.data[2];

    csr_irq_pend u_irq (
        .clk(clk), .rst(rst),
        .set_evt(eng_done), .clr_req(clr_req), .enable(cfg_irq_en),
        .pend(pend), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_start_pulse  <= 1'b0;
            cfg_soft_rst     <= 1'b0;
            cfg_irq_en       <= 1'b0;
            cfg_dst_addr     <= '0;
            cfg_first_sector <= '0;
            cfg_sector_cnt   <= '0;
        end else begin
            cfg_start_pulse <= lane0 && (wr_req.ofs == OFS_CTRL) && wr_req.data[0]
                               && !eng_busy && (cfg_sector_cnt != '0);
            cfg_soft_rst    <= lane0 && (wr_req.ofs == OFS_SRST) && wr_req.data[0];
            if (wr_fire) begin
                case (wr_req.ofs)
                    OFS_CTRL:  if (wr_req.strb[0]) cfg_irq_en <= wr_req.data[1];
                    OFS_DST:   cfg_dst_addr <= merge_lanes(cfg_dst_addr, wr_req.data, wr_req.strb);
                    OFS_SECT:  cfg_first_sector <= merge_lanes(cfg_first_sector, wr_req.data, wr_req.strb);
                    OFS_COUNT: cfg_sector_cnt <= merge_lanes(cfg_sector_cnt, wr_req.data, wr_req.strb)
                                                 & COUNT_KEEP;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        stat_now = '{state: eng_card_state, kind: eng_card_kind,
                     pend: pend, err: eng_dma_err, busy: eng_busy};
        case (rd_ofs)
            OFS_CTRL:  rd_word = {30'b0, cfg_irq_en, 1'b0};
            OFS_STAT:  rd_word = {23'b0, stat_now};
            OFS_DST:   rd_word = cfg_dst_addr;
            OFS_SECT:  rd_word = cfg_first_sector;
            OFS_COUNT: rd_word = cfg_sector_cnt;
            OFS_PROG:  rd_word = eng_bytes_done;
            default:   rd_word = '0;
        endcase
    end
endmodule

// File: rtl/dma_csr_bank_checks.sv
module dma_csr_bank_checks (
    input logic        clk,
    input logic        rst,
    input logic        s_bvalid,
    input logic        s_bready,
    input logic        s_rvalid,
    input logic        s_rready,
    input logic [31:0] s_rdata,
    input logic        cfg_start_pulse,
    input logic        cfg_soft_rst,
    input logic [31:0] cfg_sector_cnt,
    input logic        cfg_irq_en,
    input logic        eng_busy,
    input logic        eng_done,
    input logic        irq
);
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cfg_start_pulse |=> !cfg_start_pulse); // R5
    AST_START_IDLE_ONLY: assert property (@(posedge clk) disable iff (rst)
        cfg_start_pulse |-> $past(!eng_busy) && (cfg_sector_cnt != 32'd0)); // R5
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq |-> cfg_irq_en); // R8
    AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> (irq || !cfg_irq_en)); // R7
    AST_SRST_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cfg_soft_rst |=> !cfg_soft_rst); // R10
    AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        (s_bvalid && !s_bready) |=> s_bvalid); // R11
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata))); // R12
endmodule

bind dma_csr_bank dma_csr_bank_checks u_checks (
    .clk(clk), .rst(rst),
    .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
    .cfg_start_pulse(cfg_start_pulse), .cfg_soft_rst(cfg_soft_rst),
    .cfg_sector_cnt(cfg_sector_cnt), .cfg_irq_en(cfg_irq_en),
    .eng_busy(eng_busy), .eng_done(eng_done), .irq(irq)
);

// File: tb/dma_csr_bank_bench.sv
module dma_csr_bank_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] s_awaddr = '0;
    logic        s_awvalid = 1'b0;
    logic        s_awready;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic        s_wvalid = 1'b0;
    logic        s_wready;
    logic [1:0]  s_bresp;
    logic        s_bvalid;
    logic        s_bready = 1'b0;
    logic [31:0] s_araddr = '0;
    logic        s_arvalid = 1'b0;
    logic        s_arready;
    logic [31:0] s_rdata;
    logic [1:0]  s_rresp;
    logic        s_rvalid;
    logic        s_rready = 1'b0;
    logic        cfg_start_pulse;
    logic [31:0] cfg_dst_addr;
    logic [31:0] cfg_first_sector;
    logic [31:0] cfg_sector_cnt;
    logic        cfg_irq_en;
    logic        cfg_soft_rst;
    logic        eng_busy = 1'b0;
    logic        eng_dma_err = 1'b0;
    logic [3:0]  eng_card_state = '0;
    logic [1:0]  eng_card_kind = '0;
    logic [31:0] eng_bytes_done = '0;
    logic        eng_done = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int start_seen = 0;
    int srst_seen = 0;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_csr_bank u_dma_csr_bank (.*);

    always @(posedge clk) begin
        if (!rst) begin
            start_seen <= start_seen + int'(cfg_start_pulse);
            srst_seen  <= srst_seen + int'(cfg_soft_rst);
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // order: 0 = together, 1 = address first, 2 = data first
    task automatic axi_write(input logic [31:0] addr, input logic [31:0] data,
                             input logic [3:0] strb, input int order);
        logic aw_done;
        logic w_done;
        logic aw_hs;
        logic w_hs;
        aw_done = 1'b0;
        w_done  = 1'b0;
        @(negedge clk);
        s_awaddr = addr;
        s_wdata  = data;
        s_wstrb  = strb;
        if (order != 2) s_awvalid = 1'b1;
        if (order != 1) s_wvalid = 1'b1;
        while (!(aw_done && w_done)) begin
            aw_hs = s_awvalid && s_awready;
            w_hs  = s_wvalid && s_wready;
            @(posedge clk);
            @(negedge clk);
            if (aw_hs) begin s_awvalid = 1'b0; aw_done = 1'b1; end
            if (w_hs)  begin s_wvalid = 1'b0;  w_done = 1'b1;  end
            if (aw_done && !w_done && !s_wvalid) s_wvalid = 1'b1;
            if (w_done && !aw_done && !s_awvalid) s_awvalid = 1'b1;
        end
        s_bready = 1'b1;
        while (!s_bvalid) @(negedge clk);
        check("R11 bresp", {30'b0, s_bresp}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        s_bready = 1'b0;
        check("R11 one response per write", {31'b0, s_bvalid}, 32'h0);
        @(negedge clk);
    endtask

    task automatic axi_read(input logic [31:0] addr, output logic [31:0] data);
        @(negedge clk);
        s_araddr  = addr;
        s_arvalid = 1'b1;
        s_rready  = 1'b1;
        while (!s_arready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        s_arvalid = 1'b0;
        data = s_rdata;
        check("R12 rresp", {30'b0, s_rresp}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        s_rready = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 start", {31'b0, cfg_start_pulse}, 0);
        check("R1 dst", cfg_dst_addr, 0);
        check("R1 sector", cfg_first_sector, 0);
        check("R1 count", cfg_sector_cnt, 0);
        check("R1 irq_en", {31'b0, cfg_irq_en}, 0);
        check("R1 soft rst", {31'b0, cfg_soft_rst}, 0);
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 bvalid", {31'b0, s_bvalid}, 0);
        check("R1 rvalid", {31'b0, s_rvalid}, 0);
        axi_read(32'h00, v); check("R1 ctrl read", v, 0);
        axi_read(32'h08, v); check("R1 dst read", v, 0);
        axi_read(32'h10, v); check("R1 count read", v, 0);
    endtask

    task automatic t_addr_regs();
        logic [31:0] v;
        axi_write(32'h08, 32'hDEAD_BEEF, 4'hF, 0);
        axi_read(32'h08, v);
        check("R2 dst readback", v, 32'hDEAD_BEEF);
        check("R2 dst output", cfg_dst_addr, 32'hDEAD_BEEF);
        axi_write(32'h0C, 32'hA5A5_A5A5, 4'hF, 1);
        axi_write(32'h0C, 32'h1234_5678, 4'b0011, 2);
        axi_read(32'h0C, v);
        check("R2 sector strobes", v, 32'hA5A5_5678);
        check("R2 sector output", cfg_first_sector, 32'hA5A5_5678);
        check("R11 dst kept after other write", cfg_dst_addr, 32'hDEAD_BEEF);
    endtask

    task automatic t_count();
        logic [31:0] v;
        axi_write(32'h10, 32'hFFFF_FFFF, 4'hF, 1);
        axi_read(32'h10, v);
        check("R3 count mask", v, 32'h007F_FFFE);
        axi_write(32'h10, 32'h0000_0007, 4'hF, 2);
        axi_read(32'h10, v);
        check("R3 odd forced even", v, 32'h0000_0006);
        check("R3 count output", cfg_sector_cnt, 32'h0000_0006);
    endtask

    task automatic t_ctrl_start();
        logic [31:0] v;
        int base;
        axi_write(32'h10, 32'h0, 4'hF, 0);
        base = start_seen;
        axi_write(32'h00, 32'h1, 4'hF, 0);
        check("R5 zero count ignored", start_seen, base);
        axi_write(32'h10, 32'h4, 4'hF, 0);
        eng_busy = 1'b1;
        axi_write(32'h00, 32'h3, 4'hF, 1);
        check("R5 busy ignored", start_seen, base);
        axi_read(32'h00, v);
        check("R4 ctrl read en set", v, 32'h2);
        eng_busy = 1'b0;
        axi_write(32'h00, 32'hFFFF_FFFF, 4'hF, 2);
        check("R5 one start pulse", start_seen, base + 1);
        axi_read(32'h00, v);
        check("R4 start and upper read zero", v, 32'h2);
        axi_write(32'h00, 32'h0, 4'hF, 0);
        check("R4 irq_en cleared", {31'b0, cfg_irq_en}, 0);
    endtask

    task automatic t_status();
        logic [31:0] v;
        eng_card_state = 4'hA;
        eng_card_kind  = 2'b11;
        eng_dma_err    = 1'b1;
        eng_busy       = 1'b1;
        axi_read(32'h04, v);
        check("R6 status layout", v, 32'h0000_015B);
        axi_write(32'h04, 32'hFFFF_FFFF, 4'hF, 0);
        axi_read(32'h04, v);
        check("R7 status unwritable", v, 32'h0000_015B);
        eng_card_state = 4'h3;
        eng_card_kind  = 2'b01;
        eng_dma_err    = 1'b0;
        eng_busy       = 1'b0;
        axi_read(32'h04, v);
        check("R6 status tracks inputs", v, 32'h0000_0068);
        eng_card_state = 4'h0;
        eng_card_kind  = 2'b00;
    endtask

    task automatic t_irq();
        logic [31:0] v;
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
        check("R8 irq off while disabled", {31'b0, irq}, 0);
        axi_read(32'h04, v);
        check("R7 pending set while disabled", v, 32'h4);
        axi_write(32'h00, 32'h2, 4'hF, 0);
        check("R8 irq on enable", {31'b0, irq}, 1);
        axi_write(32'h04, 32'h4, 4'hF, 0);
        check("R7 w1c clears irq", {31'b0, irq}, 0);
        axi_read(32'h04, v);
        check("R7 pending cleared", v, 32'h0);
        @(negedge clk); eng_done = 1'b1;
        axi_write(32'h04, 32'h4, 4'hF, 0);
        eng_done = 1'b0;
        axi_read(32'h04, v);
        check("R7 set wins over clear", v, 32'h4);
        check("R8 irq stays", {31'b0, irq}, 1);
        axi_write(32'h04, 32'h4, 4'hF, 0);
        axi_write(32'h00, 32'h0, 4'hF, 0);
    endtask

    task automatic t_progress();
        logic [31:0] v;
        eng_bytes_done = 32'h1234_5600;
        axi_read(32'h14, v);
        check("R9 progress read", v, 32'h1234_5600);
        axi_write(32'h14, 32'hFFFF_FFFF, 4'hF, 0);
        axi_read(32'h14, v);
        check("R9 progress not writable", v, 32'h1234_5600);
    endtask

    task automatic t_soft_rst();
        logic [31:0] v;
        int base;
        base = srst_seen;
        axi_write(32'h18, 32'h1, 4'hF, 0);
        check("R10 one reset pulse", srst_seen, base + 1);
        axi_write(32'h18, 32'h0, 4'hF, 1);
        check("R10 zero gives no pulse", srst_seen, base + 1);
        axi_read(32'h18, v);
        check("R10 reads zero", v, 0);
        check("R10 config kept", cfg_dst_addr, 32'hDEAD_BEEF);
    endtask

    task automatic t_window();
        logic [31:0] v;
        axi_read(32'h1C, v);
        check("R12 hole reads zero", v, 0);
        axi_read(32'h800, v);
        check("R12 far offset reads zero", v, 0);
        axi_write(32'hABC0_1008, 32'h0BAD_F00D, 4'hF, 0);
        check("R12 upper bits ignored on write", cfg_dst_addr, 32'h0BAD_F00D);
        axi_read(32'h5550_0008, v);
        check("R12 upper bits ignored on read", v, 32'h0BAD_F00D);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_addr_regs();
        t_count();
        t_ctrl_start();
        t_status();
        t_irq();
        t_progress();
        t_soft_rst();
        t_window();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule